// File: doc/BRIEF.md
# Pulse Swallow Feedback Divider

This block divides a fast input clock by a programmable ratio built from a dual-modulus prescaler, a swallow counter and a main counter. The prescaler divides by P+1 while the swallow counter is non-zero and by P otherwise. The swallow counter loses one count on each prescaler output. The main counter counts prescaler outputs and closes the division cycle when it expires. With a swallow value A below a main value N, one division cycle spans P·N + A input clocks. At the end of every cycle the block emits a single-clock comparison pulse, which a phase comparator downstream uses as its feedback edge.

The prescaler is ordinary synchronous logic on the same clock as the counters. A select input chooses between the two moduli P_LO (default 8) and P_HI (default 16). The swallow, main and select inputs are sampled only at a cycle boundary, so a value changed in the middle of a cycle never corrupts the cycle that is running. A low enable holds every counter at its load point and keeps the pulse output quiet.

Top module: `pswl_divider`

## Requirements
- R1: While rst_ni is low, fp_o is low, and it stays low after reset for as long as en_i stays low.
- R2: While en_i is low, fp_o is low from the next clock on. Every counter stays at its load point, so a cycle that was in progress is dropped.
- R3: The first clock edge that samples en_i high after it was low (or after reset) loads the configuration. The first fp_o pulse appears after the (R+1)-th rising edge counted from that edge, where R is the ratio of R4.
- R4: With en_i held high and a swallow value A below the effective main value N, consecutive fp_o pulses are exactly R = P·N + A clocks apart.
- R5: Each fp_o pulse is high for exactly one clock.
- R6: psel_i = 1 selects P = P_LO (default 8) and psel_i = 0 selects P = P_HI (default 16).
- R7: With A = 0 every prescaler period is P clocks long, and the ratio is P·N.
- R8: With A greater than or equal to N, the swallow counter never reaches zero within a cycle. Every prescaler period is then P+1 clocks long, and the ratio is N·(P+1).
- R9: A main value below N_MIN (default 3) is treated as N_MIN.
- R10: A change of psel_i, swallow_i or main_i during a cycle leaves that cycle's length unchanged. The new values set the length of the cycle that follows the next fp_o pulse.
- R11: The swallow counter loses exactly one count on each prescaler output and never increases within a cycle. With A = N − 1 the ratio is therefore P·N + N − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Divider enable; low holds the counters at their load point |
| psel_i | input | 1 | Prescaler modulus select: 1 for P_LO, 0 for P_HI |
| swallow_i | input | A_W (7) | Swallow count A, from 0 to 127 |
| main_i | input | N_W (11) | Main count N, from 3 to 2047 |
| fp_o | output | 1 | One-clock comparison pulse at the end of each division cycle |

## Verification
The hardest situation to reach from the ports is a configuration change that lands in the middle of a running cycle. The old values must still set that cycle's length, and the new values must take over exactly one pulse later. The stimulus writes new values in the clock just after a pulse, then times the next two intervals separately. Random configurations cover both prescaler sizes and swallow values from zero up to N − 1. These are mixed with directed cases at the limits: the largest N and A, A not below N, N below the minimum, and enable dropped during a cycle.

// File: rtl/pswl_pkg.sv
package pswl_pkg;
  typedef enum logic {
    MOD_BASE  = 1'b0,
    MOD_PLUS1 = 1'b1
  } mod_e;
endpackage

// File: rtl/pswl_prescaler.sv
module pswl_prescaler #(
  parameter int P_LO = 8,
  parameter int P_HI = 16,
  parameter int PC_W = $clog2(P_HI + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              small_i,
  input  pswl_pkg::mod_e    mod_i,
  output logic              tick_o
);
  logic [PC_W-1:0] cnt_q;
  logic [PC_W-1:0] last;

  always_comb begin
    last = small_i ? PC_W'(P_LO - 1) : PC_W'(P_HI - 1);
    if (mod_i == pswl_pkg::MOD_PLUS1) last = last + 1'b1;
  end

  assign tick_o = !clr_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pswl_swallow.sv
module pswl_swallow #(
  parameter int A_W = 7
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [A_W-1:0] val_i,
  input  logic           tick_i,
  output pswl_pkg::mod_e mod_o,
  output logic [A_W-1:0] cnt_o
);
  logic [A_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= val_i;
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign mod_o = (cnt_q != '0) ? pswl_pkg::MOD_PLUS1 : pswl_pkg::MOD_BASE;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/pswl_main.sv
module pswl_main #(
  parameter int N_W = 11
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [N_W-1:0] val_i,
  input  logic           tick_i,
  output logic           wrap_o,
  output logic [N_W-1:0] cnt_o
);
  logic [N_W-1:0] cnt_q;

  assign wrap_o = tick_i && (cnt_q == N_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= val_i;
    else if (tick_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pswl_divider.sv
module pswl_divider #(
  parameter int A_W   = 7,
  parameter int N_W   = 11,
  parameter int P_LO  = 8,
  parameter int P_HI  = 16,
  parameter int N_MIN = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           psel_i,
  input  logic [A_W-1:0] swallow_i,
  input  logic [N_W-1:0] main_i,
  output logic           fp_o
);
  localparam int PC_W = $clog2(P_HI + 1);

  logic           run_q;
  logic           clr;
  logic           load;
  logic           tick;
  logic           wrap;
  logic           psel_q;
  logic           fp_q;
  logic [N_W-1:0] n_eff;
  logic [A_W-1:0] swal_cnt;
  logic [N_W-1:0] main_cnt;
  pswl_pkg::mod_e mod_sel;

  // first enabled edge only loads; counting starts on the one after
  assign clr   = !en_i || !run_q;
  assign load  = clr || wrap;
  assign n_eff = (main_i < N_W'(N_MIN)) ? N_W'(N_MIN) : main_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      psel_q <= 1'b0;
      fp_q   <= 1'b0;
    end else begin
      run_q <= en_i;
      fp_q  <= !clr && wrap;
      if (load) psel_q <= psel_i;
    end
  end

  pswl_prescaler #(.P_LO(P_LO), .P_HI(P_HI), .PC_W(PC_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .small_i(psel_q),
    .mod_i  (mod_sel),
    .tick_o (tick)
  );

  pswl_swallow #(.A_W(A_W)) u_swal (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .val_i (swallow_i),
    .tick_i(tick),
    .mod_o (mod_sel),
    .cnt_o (swal_cnt)
  );

  pswl_main #(.N_W(N_W)) u_main (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .val_i (n_eff),
    .tick_i(tick),
    .wrap_o(wrap),
    .cnt_o (main_cnt)
  );

  assign fp_o = fp_q && en_i;
endmodule

// File: rtl/pswl_checker.sv
module pswl_checker #(
  parameter int A_W = 7,
  parameter int N_W = 11
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           en_i,
  input logic           fp_o,
  input logic           fp_q,
  input logic           run_q,
  input logic           tick,
  input logic           wrap,
  input logic [A_W-1:0] swal_cnt,
  input logic [N_W-1:0] main_cnt
);
  p_off_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !fp_o);

  p_one_shot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_o |=> !fp_o);

  p_fp_on_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fp_q) |-> $past(tick));

  p_main_live_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (main_cnt != '0));

  p_swal_down_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && en_i && !wrap) |=> (swal_cnt <= $past(swal_cnt)));
endmodule

bind pswl_divider pswl_checker #(.A_W(A_W), .N_W(N_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .fp_o    (fp_o),
  .fp_q    (fp_q),
  .run_q   (run_q),
  .tick    (tick),
  .wrap    (wrap),
  .swal_cnt(swal_cnt),
  .main_cnt(main_cnt)
);

// File: tb/test_pswl_divider.sv
module test_pswl_divider;
  localparam int A_W = 7, N_W = 11, P_LO = 8, P_HI = 16, N_MIN = 3;
  localparam int LIMIT = 40000;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           en_i = 1'b0;
  logic           psel_i = 1'b0;
  logic [A_W-1:0] swallow_i = '0;
  logic [N_W-1:0] main_i = N_W'(3);
  logic           fp_o;

  int errs = 0;
  int chks = 0;

  always #2 clk_i = ~clk_i;

  pswl_divider #(.A_W(A_W), .N_W(N_W), .P_LO(P_LO), .P_HI(P_HI), .N_MIN(N_MIN)) i_pswl_divider (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .psel_i(psel_i),
    .swallow_i(swallow_i), .main_i(main_i), .fp_o(fp_o)
  );

  function automatic int ratio(bit ps, int a, int n);
    int p  = ps ? P_LO : P_HI;
    int ne = (n < N_MIN) ? N_MIN : n;
    return (a < ne) ? p * ne + a : ne * (p + 1);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    chks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // negedges until fp_o seen high; reports whether the first one saw it low
  task automatic to_fp(output int n, output bit first_low);
    n = 0;
    first_low = 1'b1;
    do begin
      @(negedge clk_i);
      n++;
      if (n == 1) first_low = !fp_o;
    end while (!fp_o && n < LIMIT);
  endtask

  task automatic setcfg(bit ps, int a, int n);
    psel_i    = ps;
    swallow_i = A_W'(a);
    main_i    = N_W'(n);
  endtask

  task automatic run_case(bit ps, int a, int n, string req);
    int k;
    bit lo;
    int r = ratio(ps, a, n);
    @(negedge clk_i);
    en_i = 1'b0;
    setcfg(ps, a, n);
    @(negedge clk_i);
    en_i = 1'b1;
    to_fp(k, lo);
    check(k == r + 1, {req, " R3 first pulse"}, k, r + 1);
    to_fp(k, lo);
    check(k == r, {req, " period"}, k, r);
    check(lo, "R5 pulse width", 0, 1);
  endtask

  initial begin
    int k;
    bit lo;
    bit seen;
    void'($urandom(32'd20240607));

    repeat (3) @(negedge clk_i);
    check(fp_o == 1'b0, "R1 in reset", fp_o, 0);
    rst_ni = 1'b1;
    seen = 1'b0;
    repeat (80) begin
      @(negedge clk_i);
      if (fp_o) seen = 1'b1;
    end
    check(!seen, "R1 idle after reset", seen, 0);

    run_case(1'b1, 5, 10, "R4 R6 small P");
    run_case(1'b0, 5, 10, "R4 R6 large P");
    run_case(1'b1, 0, 7, "R7 A zero");
    run_case(1'b0, 0, 3, "R7 A zero min N");
    run_case(1'b1, 9, 4, "R8 A above N");
    run_case(1'b0, 6, 6, "R8 A equals N");
    run_case(1'b1, 0, 1, "R9 N below min");
    run_case(1'b0, 2, 0, "R9 N zero");
    run_case(1'b1, 11, 12, "R11 A=N-1");
    run_case(1'b1, 127, 2047, "R4 max values");

    // R2: drop enable mid cycle, expect silence, then a fresh start
    run_case(1'b0, 3, 20, "R4 pre-disable");
    repeat (50) @(negedge clk_i);
    en_i = 1'b0;
    seen = 1'b0;
    repeat (700) begin
      @(negedge clk_i);
      if (fp_o) seen = 1'b1;
    end
    check(!seen, "R2 quiet while disabled", seen, 0);
    en_i = 1'b1;
    to_fp(k, lo);
    check(k == ratio(1'b0, 3, 20) + 1, "R2 restart from load", k, ratio(1'b0, 3, 20) + 1);

    // R10: change mid cycle right after a pulse
    run_case(1'b1, 4, 9, "R10 old cfg");
    setcfg(1'b0, 7, 13);
    to_fp(k, lo);
    check(k == ratio(1'b1, 4, 9), "R10 running cycle keeps old", k, ratio(1'b1, 4, 9));
    to_fp(k, lo);
    check(k == ratio(1'b0, 7, 13), "R10 next cycle uses new", k, ratio(1'b0, 7, 13));

    for (int i = 0; i < 16; i++) begin
      bit ps = 1'($urandom);
      int n  = 3 + int'($urandom % 40);
      int a  = int'($urandom % n);
      run_case(ps, a, n, "R4 random");
    end

    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk_i);
    errs++;
    chks++;
    $display("FAIL R4 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule